// File: doc/BRIEF.md
# Tail-Biting Viterbi Traceback and Trim Unit

This unit is the back end of a wrap-around Viterbi decoder for a rate-1/3, constraint-length-7 tail-biting convolutional code. An upstream add-compare-select stage produces one 64-bit survivor word per trellis step of a cyclically extended frame. Bit s of each word is the decision of state s. That stage also reports which state ended with the best path metric. The unit stores every survivor word of the frame. After the word flagged as last, it walks the trellis backwards from the best state and recovers one decoded bit per step. It keeps only the bits of the central message span and drops the 40 training steps wrapped onto each side. It then sends the message out in its natural order, one bit per clock.

The extended frame holds M + 80 steps, where M is the message length. M is not given as an input: the unit infers it from how many survivor words arrive. While the unit is tracing or emitting, it accepts no new frame. The cycle after the output bit marked as final, it is ready for the next frame's first survivor word.

Top module: `traceback_unit`

## Requirements
- R1: While `rst` is high, and after it falls with no frame given, `bit_valid`, `bit_start` and `bit_end` are low. A reset in the middle of a traceback abandons that frame without emitting any bit.
- R2: In the collecting phase, each cycle with `dec_valid` high stores `dec_word` as the next trellis step, starting at step 0. The word with `dec_last` high is the final step, and `best_state` is sampled with it. The frame length L is the number of stored words, and M = L - 80 (1 <= M <= 256).
- R3: The traceback starts at `best_state` on step L-1. The decoded bit of step k is bit 0 of the current state. The state for step k-1 is {`dec_word`(k)[state], state[5:1]}, so the selected decision bit enters as the new bit 5.
- R4: The bits of steps L-1 down to L-40 are discarded, and so are those of steps 39 down to 0. Exactly the M bits of steps 40 to M+39 are emitted.
- R5: Output bits leave in message order, one per cycle with no gap. Message bit j is the bit of step j+40. Bit 0 carries `bit_start` and bit M-1 carries `bit_end`. Both flags are only ever high together with `bit_valid`.
- R6: Message bit 0 is valid exactly M+42 cycles after the clock edge that samples `dec_last`. Bit M-1 is valid exactly 2*M+41 cycles after that edge.
- R7: Input words offered while the unit is tracing or emitting, with or without `dec_last`, are ignored. They change neither the frame in progress nor the next frame.
- R8: The unit accepts a new frame's first word in the cycle right after the one in which `bit_end` is high.
- R9: With M = 1, the single output bit carries `bit_start` and `bit_end` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| dec_valid | input | 1 | A survivor word is present on `dec_word` |
| dec_last | input | 1 | This survivor word is the final trellis step of the frame |
| dec_word | input | 64 | Survivor decisions, bit s for state s |
| best_state | input | 6 | State with the best final metric, sampled with `dec_last` |
| bit_out | output | 1 | Decoded message bit |
| bit_start | output | 1 | Marks message bit 0 |
| bit_end | output | 1 | Marks message bit M-1 |
| bit_valid | output | 1 | `bit_out` holds a message bit |

## Verification
Timing is fixed by the pipeline. The edge that samples `dec_last` is followed by one read-issue cycle and then M+40 traceback steps. The first emit cycle comes after those, so message bit 0 appears M+42 cycles after the edge and bit M-1 appears M-1 cycles after bit 0. The bench notes the cycle count when it drives the last word. It drives inputs and samples outputs on the falling edge, compares the cycle of the first and last valid bits against those two figures, and checks every bit against a message it encoded itself into a consistent trellis.

// File: rtl/tbk_pkg.sv
package tbk_pkg;

  // Operating phase of the traceback unit
  typedef enum logic [1:0] {
    PH_COLLECT = 2'd0,
    PH_TRACE   = 2'd1,
    PH_EMIT    = 2'd2
  } tbk_phase_t;

  // Number of trellis steps in an extended frame
  function automatic int unsigned span_len(input int unsigned msg_len, input int unsigned train_len);
    return msg_len + 2 * train_len;
  endfunction

endpackage

// File: rtl/tbk_sync_ram.sv
// Simple dual-port RAM with registered read, suitable for block RAM.
module tbk_sync_ram #(
  parameter int WIDTH = 64,
  parameter int DEPTH = 336,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/tbk_state_walker.sv
// Holds the traceback state and steps it one trellis stage backwards.
module tbk_state_walker #(
  parameter int SW = 6,
  localparam int NS = 1 << SW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [SW-1:0] load_state,
  input  logic          step,
  input  logic [NS-1:0] dec_word,
  output logic [SW-1:0] state
);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= '0;
    end else if (load) begin
      state <= load_state;
    end else if (step) begin
      state <= {dec_word[state], state[SW-1:1]};
    end
  end

  // R3
  walk_shift_chk: assert property (@(posedge clk) disable iff (rst)
    (step && !load) |=> state[SW-2:0] == $past(state[SW-1:1]));

  // R3
  walk_load_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> state == $past(load_state));

endmodule

// File: rtl/traceback_unit.sv
// Stores a wrap-extended frame of survivor words, traces back from the best
// state, trims the training steps and emits the message in forward order.
module traceback_unit #(
  parameter int CONSTRAINT_LEN = 7,
  parameter int TRAIN_LEN      = 40,
  parameter int MAX_MSG        = 256
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               dec_valid,
  input  logic                               dec_last,
  input  logic [(1<<(CONSTRAINT_LEN-1))-1:0] dec_word,
  input  logic [CONSTRAINT_LEN-2:0]          best_state,
  output logic                               bit_out,
  output logic                               bit_start,
  output logic                               bit_end,
  output logic                               bit_valid
);
  import tbk_pkg::*;

  localparam int SW       = CONSTRAINT_LEN - 1;
  localparam int NS       = 1 << SW;
  localparam int MAX_SPAN = span_len(MAX_MSG, TRAIN_LEN);
  localparam int DAW      = $clog2(MAX_SPAN);
  localparam int BAW      = (MAX_MSG > 1) ? $clog2(MAX_MSG) : 1;
  localparam logic [DAW-1:0] TRAIN_IDX  = DAW'(TRAIN_LEN);
  localparam logic [DAW-1:0] D_ONE      = DAW'(1);
  localparam logic [BAW-1:0] B_ONE      = BAW'(1);
  localparam logic [DAW:0]   MAX_SPAN_V = (DAW+1)'(MAX_SPAN);

  tbk_phase_t     phase;
  logic [DAW-1:0] wr_ptr;      // next survivor word address
  logic [DAW-1:0] rd_ptr;      // survivor word address being read
  logic [DAW-1:0] step_idx;    // trellis step whose word is on ram_q
  logic [DAW-1:0] keep_hi;     // highest step inside the message span
  logic           pipe_ok;     // ram_q holds the word of step_idx
  logic           emit_first;
  logic [BAW-1:0] lifo_wr;
  logic [BAW-1:0] lifo_rd;
  logic [NS-1:0]  ram_q;
  logic [SW-1:0]  walk_state;

  logic accept, frame_close, ram_re, step_en, keep_en, lifo_re;

  always_comb begin
    accept      = (phase == PH_COLLECT) && dec_valid;
    frame_close = accept && dec_last;
    ram_re      = (phase == PH_TRACE);
    step_en     = (phase == PH_TRACE) && pipe_ok;
    keep_en     = step_en && (step_idx <= keep_hi);
    lifo_re     = (phase == PH_EMIT);
  end

  tbk_sync_ram #(.WIDTH(NS), .DEPTH(MAX_SPAN)) u_dec_ram (
    .clk   (clk),
    .we    (accept),
    .waddr (wr_ptr),
    .wdata (dec_word),
    .re    (ram_re),
    .raddr (rd_ptr),
    .rdata (ram_q)
  );

  tbk_state_walker #(.SW(SW)) u_walker (
    .clk        (clk),
    .rst        (rst),
    .load       (frame_close),
    .load_state (best_state),
    .step       (step_en),
    .dec_word   (ram_q),
    .state      (walk_state)
  );

  tbk_sync_ram #(.WIDTH(1), .DEPTH(MAX_MSG)) u_lifo (
    .clk   (clk),
    .we    (keep_en),
    .waddr (lifo_wr),
    .wdata (walk_state[0]),
    .re    (lifo_re),
    .raddr (lifo_rd),
    .rdata (bit_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase      <= PH_COLLECT;
      wr_ptr     <= '0;
      rd_ptr     <= '0;
      step_idx   <= '0;
      keep_hi    <= '0;
      pipe_ok    <= 1'b0;
      emit_first <= 1'b0;
      lifo_wr    <= '0;
      lifo_rd    <= '0;
      bit_valid  <= 1'b0;
      bit_start  <= 1'b0;
      bit_end    <= 1'b0;
    end else begin
      bit_valid <= 1'b0;
      bit_start <= 1'b0;
      bit_end   <= 1'b0;
      unique case (phase)
        PH_COLLECT: begin
          if (dec_valid) begin
            if (dec_last) begin
              rd_ptr  <= wr_ptr;
              keep_hi <= wr_ptr - TRAIN_IDX;
              wr_ptr  <= '0;
              pipe_ok <= 1'b0;
              lifo_wr <= '0;
              phase   <= PH_TRACE;
            end else begin
              wr_ptr <= wr_ptr + D_ONE;
            end
          end
        end
        PH_TRACE: begin
          rd_ptr   <= rd_ptr - D_ONE;
          step_idx <= rd_ptr;
          pipe_ok  <= 1'b1;
          if (pipe_ok) begin
            if (keep_en) lifo_wr <= lifo_wr + B_ONE;
            if (step_idx == TRAIN_IDX) begin
              lifo_rd    <= lifo_wr;
              emit_first <= 1'b1;
              pipe_ok    <= 1'b0;
              phase      <= PH_EMIT;
            end
          end
        end
        PH_EMIT: begin
          bit_valid  <= 1'b1;
          bit_start  <= emit_first;
          emit_first <= 1'b0;
          bit_end    <= (lifo_rd == '0);
          lifo_rd    <= lifo_rd - B_ONE;
          if (lifo_rd == '0) phase <= PH_COLLECT;
        end
        default: phase <= PH_COLLECT;
      endcase
    end
  end

  // R2
  span_fit_chk: assert property (@(posedge clk) disable iff (rst)
    accept |-> {1'b0, wr_ptr} < MAX_SPAN_V);

  // R5
  first_is_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(bit_valid) |-> bit_start);

  // R5
  burst_contig_chk: assert property (@(posedge clk) disable iff (rst)
    (bit_valid && !bit_end) |=> bit_valid);

  // R5
  flags_need_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (bit_start || bit_end) |-> bit_valid);

  // R8
  end_closes_chk: assert property (@(posedge clk) disable iff (rst)
    bit_end |=> !bit_valid);

endmodule

// File: tb/tb_traceback_unit.sv
module tb_traceback_unit;
  localparam int SW   = 6;
  localparam int NS   = 64;
  localparam int T    = 40;
  localparam int MAXM = 256;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          dec_valid = 1'b0;
  logic          dec_last = 1'b0;
  logic [NS-1:0] dec_word = '0;
  logic [SW-1:0] best_state = '0;
  logic          bit_out, bit_start, bit_end, bit_valid;

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  int cur_m = 1;
  bit msg [MAXM];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  traceback_unit #(.CONSTRAINT_LEN(7), .TRAIN_LEN(T), .MAX_MSG(MAXM)) dut (
    .clk(clk), .rst(rst), .dec_valid(dec_valid), .dec_last(dec_last),
    .dec_word(dec_word), .best_state(best_state), .bit_out(bit_out),
    .bit_start(bit_start), .bit_end(bit_end), .bit_valid(bit_valid)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Encoder input at extended step n (any integer, wraps cyclically)
  function automatic bit uext(input int n);
    int i;
    i = ((n - T) % cur_m + cur_m) % cur_m;
    return msg[i];
  endfunction

  // Encoder state after step k: bit i is the input of step k-i
  function automatic logic [SW-1:0] st_at(input int k);
    logic [SW-1:0] s;
    for (int i = 0; i < SW; i++) s[i] = uext(k - i);
    return s;
  endfunction

  // Survivor word: noise everywhere, true predecessor bit on the true state
  function automatic logic [NS-1:0] word_at(input int k, input int seed);
    logic [NS-1:0] w;
    for (int s = 0; s < NS; s++) w[s] = ^(32'(k * 73 + s * 29 + seed * 11 + (k * s) % 13));
    w[st_at(k)] = uext(k - SW);
    return w;
  endfunction

  task automatic fill_msg(input int m, input int seed);
    cur_m = m;
    for (int j = 0; j < m; j++) msg[j] = ^(32'(j * 37 + seed * 101 + (j * j) % 17));
  endtask

  // Starts and ends on a falling edge
  task automatic drive_frame(input int m, input int seed, output int c0);
    int len;
    len = m + 2 * T;
    c0 = 0;
    for (int k = 0; k < len; k++) begin
      dec_valid  = 1'b1;
      dec_word   = word_at(k, seed);
      dec_last   = (k == len - 1);
      best_state = st_at(len - 1);
      if (k == len - 1) c0 = cyc;
      @(negedge clk);
    end
  endtask

  task automatic run_frame(input int m, input int seed, input bit junk, input string tag);
    int c0;
    int got;
    bit done;
    fill_msg(m, seed);
    drive_frame(m, seed, c0);
    got = 0;
    done = 1'b0;
    for (int w = 0; w < 2 * m + T + 20 && !done; w++) begin
      if (bit_valid) begin
        if (got == 0)
          check(cyc == c0 + m + T + 3, "R6", {tag, " first bit cycle"}, cyc - c0 - 1, m + T + 2);
        check(bit_out == msg[got], "R3", {tag, " decoded bit"}, int'(bit_out), int'(msg[got]));
        check(bit_start == (got == 0), "R5", {tag, " start flag"}, int'(bit_start), int'(got == 0));
        check(bit_end == (got == m - 1), "R5", {tag, " end flag"}, int'(bit_end), int'(got == m - 1));
        if (bit_end) begin
          check(cyc == c0 + 2 * m + T + 2, "R6", {tag, " last bit cycle"}, cyc - c0 - 1, 2 * m + T + 1);
          done = 1'b1;
        end
        got++;
      end else if (got > 0) begin
        check(1'b0, "R5", {tag, " gap in burst"}, 0, 1);
      end
      if (done) begin
        dec_valid = 1'b0;
        dec_last  = 1'b0;
      end else if (junk) begin
        dec_valid  = 1'b1;
        dec_last   = (cyc % 5 == 0);
        dec_word   = '1;
        best_state = SW'(cyc);
      end else begin
        dec_valid = 1'b0;
        dec_last  = 1'b0;
      end
      if (!done) @(negedge clk);
    end
    check(got == m, "R4", {tag, " emitted bit count"}, got, m);
  endtask

  task automatic reset_abort(input int m, input int seed);
    int c0;
    int seen;
    fill_msg(m, seed);
    drive_frame(m, seed, c0);
    dec_valid = 1'b0;
    dec_last  = 1'b0;
    repeat (10) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check(!bit_valid && !bit_start && !bit_end, "R1", "outputs during mid-trace reset",
          int'(bit_valid), 0);
    rst = 1'b0;
    seen = 0;
    repeat (2 * m + T + 10) begin
      @(negedge clk);
      if (bit_valid) seen++;
    end
    check(seen == 0, "R1", "bits emitted after abandoned frame", seen, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(bit_valid == 1'b0, "R1", "valid in reset", int'(bit_valid), 0);
    check(bit_start == 1'b0, "R1", "start in reset", int'(bit_start), 0);
    check(bit_end == 1'b0, "R1", "end in reset", int'(bit_end), 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check(bit_valid == 1'b0, "R1", "valid idle after reset", int'(bit_valid), 0);

    run_frame(1, 3, 1'b0, "R9 single-bit message");
    run_frame(5, 7, 1'b0, "R2 M=5");
    run_frame(37, 11, 1'b0, "R2 M=37");
    run_frame(MAXM, 19, 1'b0, "R4 maximum length");
    run_frame(20, 23, 1'b1, "R7 input offered while busy");
    run_frame(12, 29, 1'b0, "R7 frame after busy input");
    run_frame(12, 31, 1'b0, "R8 back-to-back first");
    run_frame(64, 37, 1'b0, "R8 back-to-back second");
    reset_abort(30, 41);
    run_frame(9, 43, 1'b0, "R1 frame after aborted one");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule